// File: doc/BRIEF.md
# Encoder Host Command Decoder and Reply Queue

This block sits between a 32-bit SPI slave shift register and an absolute-encoder line engine. Each completed SPI transaction gives it one received datagram. The top byte of that datagram chooses the action. An encoder opcode starts one request on the request stream. A version or protocol opcode queues an answer locally. A zero byte is a dummy that only moves reply data out.

When the encoder engine returns a response, the block packs the fields into tagged 32-bit words and loads them into a short reply queue. The tag byte names each word's contents. The head of the queue is the word that the next SPI transaction shifts out. Every transaction that starts while words are queued consumes exactly one word. The host therefore drains a reply with dummy transactions, and the last of them may already carry the next command.

The SPI side has no back-pressure: `dg_valid` is a single-cycle pulse, and the datagram is always taken. The request and response sides are valid/ready streams. `req_valid` stays high with stable fields until `req_ready` is seen. `rsp_ready` is high only while a request is outstanding, and the response fields are taken in the cycle where `rsp_valid` and `rsp_ready` are both high.

Top module: `encspi_host_front`

## Requirements
- R1: Top bytes 0x80, 0x81, 0x82, 0x83, 0x86, 0x87, 0x88, 0x8C and 0x8D, accepted while nothing is pending, each raise exactly one request whose `req_id` is the low nibble of that byte (0, 1, 2, 3, 6, 7, 8, C, D).
- R2: On a request, `req_data` carries datagram bits 15:8 and `req_addr` carries bits 6:0. These are the write data and address for ID 6, and the address for ID D.
- R3: A response to ID 0, 7, 8 or C queues two words in this order:
  - `{0x10, rsp_pos[23:0]}`;
  - the status word `{0x70, rsp_status, rsp_crc_rx, rsp_crc_calc}`.
- R4: A response to ID 1 queues `{0x20, rsp_turns}` then the status word. A response to ID 2 queues `{0x40, 0x0000, rsp_enc_id}` then the status word.
- R5: A response to ID 3 queues five words in this order:
  - `{0x10, pos}`;
  - `{0x40, 0x0000, enc_id}`;
  - `{0x20, turns}`;
  - `{0x50, 0x0000, rsp_alarm}`;
  - the status word.
- R6: A response to ID 6 or D queues `{0x50, 0x00, rsp_mem_data, rsp_mem_addr}` then the status word.
- R7: Top byte 0xFF queues the single word `{0xFF, 0x00, VER_MAJOR, VER_MINOR}`. Top byte 0xFE queues `0x54414D54`. Neither raises a request.
- R8: While words are queued, `tx_word` is the oldest of them, and each `dg_valid` pulse removes that word. While the queue is empty, `tx_word` is zero. A datagram with top byte 0x00 has no other effect.
- R9: `data_avail` rises in the cycle after a reply is loaded. It falls in the cycle after the transaction that removes the last word.
- R10: A command in the transaction that removes the last queued word is accepted as if the queue were empty.
- R11: A nonzero top byte is ignored, and sets `cmd_err`, in either case:
  - words are still queued after that transaction's removal;
  - a request or its response is outstanding.

  `cmd_err` stays set until reset.
- R12: `req_valid` holds with stable fields until `req_ready`. `rsp_ready` is high only after the request handshake and until the response is taken.
- R13: A nonzero top byte not listed in R1 or R7, arriving while nothing is pending, raises no request, queues nothing and leaves `cmd_err` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dg_valid | input | 1 | One-cycle pulse: an SPI transaction completed |
| dg_data | input | 32 | Datagram received in that transaction |
| tx_word | output | 32 | Word to load into the SPI shift register for the next transaction |
| data_avail | output | 1 | Reply words are queued |
| cmd_err | output | 1 | Sticky flag: a command arrived while pending |
| req_valid | output | 1 | Encoder request valid |
| req_ready | input | 1 | Encoder engine accepts the request |
| req_id | output | 4 | Encoder transaction ID |
| req_addr | output | 7 | Memory address (datagram bits 6:0) |
| req_data | output | 8 | Memory write data (datagram bits 15:8) |
| rsp_valid | input | 1 | Encoder response valid |
| rsp_ready | output | 1 | Block is waiting for a response |
| rsp_status | input | 8 | Status field |
| rsp_pos | input | 24 | Single-turn position |
| rsp_turns | input | 24 | Multiturn count |
| rsp_enc_id | input | 8 | Encoder identity byte |
| rsp_alarm | input | 8 | Alarm byte |
| rsp_mem_addr | input | 8 | Memory address echoed by the encoder |
| rsp_mem_data | input | 8 | Memory data echoed by the encoder |
| rsp_crc_rx | input | 8 | CRC received from the encoder |
| rsp_crc_calc | input | 8 | CRC computed over the received fields |

## Verification
The assertions take three things for granted about the inputs:
- `dg_valid` is a single-cycle pulse;
- `req_ready` is only honoured while `req_valid` is high;
- `rsp_valid` means nothing outside the window in which `rsp_ready` is high.

The stimulus pulses `dg_valid` for exactly one cycle, raises `req_ready` only after it sees a request, and drives a response only once `rsp_ready` is observed. It sends every command outside R1 and R7 only while the block is idle, except in the R11 cases, where commands are deliberately aimed at an outstanding request and at a partly drained queue.

// File: rtl/encspi_pkg.sv
package encspi_pkg;
  typedef enum logic [1:0] {CK_NONE, CK_ENC, CK_VER, CK_PROTO} cmd_kind_e;

  localparam int PACK_N  = 5;
  localparam int PACK_CW = $clog2(PACK_N + 1);

  localparam logic [7:0]  TAG_POS    = 8'h10;
  localparam logic [7:0]  TAG_TURN   = 8'h20;
  localparam logic [7:0]  TAG_EID    = 8'h40;
  localparam logic [7:0]  TAG_AUX    = 8'h50;
  localparam logic [7:0]  TAG_STAT   = 8'h70;
  localparam logic [7:0]  TAG_VER    = 8'hFF;
  localparam logic [31:0] PROTO_WORD = 32'h54414D54;
endpackage

// File: rtl/encspi_cmd_decode.sv
module encspi_cmd_decode
  import encspi_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_kind_e  kind,
  output logic [3:0] enc_id
);
  always_comb begin
    kind   = CK_NONE;
    enc_id = 4'h0;
    case (cmd_byte)
      8'h80, 8'h81, 8'h82, 8'h83, 8'h86,
      8'h87, 8'h88, 8'h8C, 8'h8D: begin
        kind   = CK_ENC;
        enc_id = cmd_byte[3:0];
      end
      8'hFF:   kind = CK_VER;
      8'hFE:   kind = CK_PROTO;
      default: kind = CK_NONE;
    endcase
  end
endmodule

// File: rtl/encspi_reply_pack.sv
module encspi_reply_pack
  import encspi_pkg::*;
#(
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h00
) (
  input  cmd_kind_e                   kind,
  input  logic [3:0]                  enc_id,
  input  logic [7:0]                  status,
  input  logic [23:0]                 pos,
  input  logic [23:0]                 turns,
  input  logic [7:0]                  eid,
  input  logic [7:0]                  alarm,
  input  logic [7:0]                  mem_addr,
  input  logic [7:0]                  mem_data,
  input  logic [7:0]                  crc_rx,
  input  logic [7:0]                  crc_calc,
  output logic [PACK_N-1:0][31:0]     words,
  output logic [PACK_CW-1:0]          count
);
  logic [31:0] w_stat, w_pos, w_turn, w_eid, w_alm, w_mem;

  assign w_stat = {TAG_STAT, status, crc_rx, crc_calc};
  assign w_pos  = {TAG_POS, pos};
  assign w_turn = {TAG_TURN, turns};
  assign w_eid  = {TAG_EID, 16'h0000, eid};
  assign w_alm  = {TAG_AUX, 16'h0000, alarm};
  assign w_mem  = {TAG_AUX, 8'h00, mem_data, mem_addr};

  always_comb begin
    words = '0;
    count = '0;
    case (kind)
      CK_VER: begin
        words[0] = {TAG_VER, 8'h00, VER_MAJOR, VER_MINOR};
        count    = PACK_CW'(1);
      end
      CK_PROTO: begin
        words[0] = PROTO_WORD;
        count    = PACK_CW'(1);
      end
      CK_ENC: begin
        case (enc_id)
          4'h1: begin
            words[0] = w_turn; words[1] = w_stat; count = PACK_CW'(2);
          end
          4'h2: begin
            words[0] = w_eid;  words[1] = w_stat; count = PACK_CW'(2);
          end
          4'h3: begin
            words[0] = w_pos;  words[1] = w_eid;  words[2] = w_turn;
            words[3] = w_alm;  words[4] = w_stat; count = PACK_CW'(5);
          end
          4'h6, 4'hD: begin
            words[0] = w_mem;  words[1] = w_stat; count = PACK_CW'(2);
          end
          default: begin
            words[0] = w_pos;  words[1] = w_stat; count = PACK_CW'(2);
          end
        endcase
      end
      default: count = '0;
    endcase
  end
endmodule

// File: rtl/encspi_reply_buf.sv
module encspi_reply_buf
  import encspi_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [PACK_N-1:0][31:0] load_words,
  input  logic [PACK_CW-1:0]      load_cnt,
  input  logic                    pop,
  output logic [31:0]             head,
  output logic [CNT_W-1:0]        count
);
  logic [DEPTH-1:0][31:0] ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [31:0] fill_w, next_w;
    if (i < PACK_N) begin : g_fill
      assign fill_w = load_words[i];
    end else begin : g_nofill
      assign fill_w = '0;
    end
    if (i < DEPTH - 1) begin : g_shift
      assign next_w = ent[i+1];
    end else begin : g_last
      assign next_w = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ent[i] <= '0;
      else if (load)                 ent[i] <= fill_w;
      else if (pop && count != '0)   ent[i] <= next_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (load)                 count <= CNT_W'(load_cnt);
    else if (pop && count != '0)   count <= count - CNT_W'(1);
  end

  assign head = ent[0];

  // R8: each removal takes exactly one word
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load && count != '0) |=> count == $past(count) - CNT_W'(1));

  // R10: a reply is only loaded into a queue that is empty after this cycle's removal
  a_r10_load_empty: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (count == '0 || (pop && count == CNT_W'(1))));
endmodule

// File: rtl/encspi_host_front.sv
module encspi_host_front
  import encspi_pkg::*;
#(
  parameter int         DEPTH     = 8,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dg_valid,
  input  logic [31:0] dg_data,
  output logic [31:0] tx_word,
  output logic        data_avail,
  output logic        cmd_err,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [3:0]  req_id,
  output logic [6:0]  req_addr,
  output logic [7:0]  req_data,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_status,
  input  logic [23:0] rsp_pos,
  input  logic [23:0] rsp_turns,
  input  logic [7:0]  rsp_enc_id,
  input  logic [7:0]  rsp_alarm,
  input  logic [7:0]  rsp_mem_addr,
  input  logic [7:0]  rsp_mem_data,
  input  logic [7:0]  rsp_crc_rx,
  input  logic [7:0]  rsp_crc_calc
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  state_e                  state;
  cmd_kind_e               dec_kind, pk_kind;
  logic [3:0]              dec_id;
  logic [PACK_N-1:0][31:0] pk_words;
  logic [PACK_CW-1:0]      pk_cnt;
  logic [31:0]             buf_head;
  logic [CNT_W-1:0]        buf_cnt, remain;
  logic pop, is_cmd, blocked, accept, start_enc, local_load, rsp_take, buf_load;

  encspi_cmd_decode u_dec (
    .cmd_byte (dg_data[31:24]),
    .kind     (dec_kind),
    .enc_id   (dec_id)
  );

  assign pop        = dg_valid && (buf_cnt != '0);
  assign remain     = buf_cnt - CNT_W'(pop);
  assign is_cmd     = dg_valid && (dg_data[31:24] != 8'h00);
  assign blocked    = is_cmd && ((remain != '0) || (state != ST_IDLE));
  assign accept     = is_cmd && !blocked;
  assign start_enc  = accept && (dec_kind == CK_ENC);
  assign local_load = accept && (dec_kind == CK_VER || dec_kind == CK_PROTO);
  assign rsp_ready  = (state == ST_WAIT);
  assign req_valid  = (state == ST_REQ);
  assign rsp_take   = rsp_valid && rsp_ready;
  assign buf_load   = local_load || rsp_take;
  assign pk_kind    = rsp_take ? CK_ENC : dec_kind;

  encspi_reply_pack #(.VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_pack (
    .kind     (pk_kind),
    .enc_id   (req_id),
    .status   (rsp_status),
    .pos      (rsp_pos),
    .turns    (rsp_turns),
    .eid      (rsp_enc_id),
    .alarm    (rsp_alarm),
    .mem_addr (rsp_mem_addr),
    .mem_data (rsp_mem_data),
    .crc_rx   (rsp_crc_rx),
    .crc_calc (rsp_crc_calc),
    .words    (pk_words),
    .count    (pk_cnt)
  );

  encspi_reply_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (buf_load),
    .load_words (pk_words),
    .load_cnt   (pk_cnt),
    .pop        (pop),
    .head       (buf_head),
    .count      (buf_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_id   <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_enc) begin
          state    <= ST_REQ;
          req_id   <= dec_id;
          req_addr <= dg_data[6:0];
          req_data <= dg_data[15:8];
        end
        ST_REQ:  if (req_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_take)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_err <= 1'b0;
    else if (blocked) cmd_err <= 1'b1;
  end

  assign data_avail = (buf_cnt != '0);
  assign tx_word    = data_avail ? buf_head : 32'h0;

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_id) &&
                                   $stable(req_addr) && $stable(req_data)));

  a_r12_rsp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  a_r9_avail_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(dg_valid));

  a_r1_id_legal: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_id inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7, 4'h8, 4'hC, 4'hD}));
endmodule

// File: tb/encspi_host_front_tb.sv
module encspi_host_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dg_valid = 1'b0;
  logic [31:0] dg_data = '0;
  logic [31:0] tx_word;
  logic        data_avail, cmd_err, req_valid, rsp_ready;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [3:0]  req_id;
  logic [6:0]  req_addr;
  logic [7:0]  req_data;
  logic [7:0]  r_sf = '0, r_eid = '0, r_alm = '0, r_madr = '0, r_mdat = '0, r_crx = '0, r_ccal = '0;
  logic [23:0] r_pos = '0, r_turn = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       exp_tag_q[$];
  logic [31:0] obs_q[$];

  always #10 clk = ~clk;

  encspi_host_front dut_i (
    .clk(clk), .rst_n(rst_n), .dg_valid(dg_valid), .dg_data(dg_data),
    .tx_word(tx_word), .data_avail(data_avail), .cmd_err(cmd_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_status(r_sf), .rsp_pos(r_pos),
    .rsp_turns(r_turn), .rsp_enc_id(r_eid), .rsp_alarm(r_alm),
    .rsp_mem_addr(r_madr), .rsp_mem_data(r_mdat), .rsp_crc_rx(r_crx),
    .rsp_crc_calc(r_ccal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] w, input string tag);
    exp_q.push_back(w);
    exp_tag_q.push_back(tag);
  endtask

  // expected reply list, built from the requirement text
  task automatic push_exp(input logic [3:0] id);
    logic [31:0] st;
    st = {8'h70, r_sf, r_crx, r_ccal};
    case (id)
      4'h1: begin expect_word({8'h20, r_turn}, "R4"); expect_word(st, "R4"); end
      4'h2: begin expect_word({8'h40, 16'h0, r_eid}, "R4"); expect_word(st, "R4"); end
      4'h3: begin
        expect_word({8'h10, r_pos}, "R5");  expect_word({8'h40, 16'h0, r_eid}, "R5");
        expect_word({8'h20, r_turn}, "R5"); expect_word({8'h50, 16'h0, r_alm}, "R5");
        expect_word(st, "R5");
      end
      4'h6, 4'hD: begin expect_word({8'h50, 8'h00, r_mdat, r_madr}, "R6"); expect_word(st, "R6"); end
      default: begin expect_word({8'h10, r_pos}, "R3"); expect_word(st, "R3"); end
    endcase
  endtask

  // monitor: compares every word read out against the scoreboard
  always @(negedge clk) begin
    while (obs_q.size() > 0) begin
      logic [31:0] got;
      got = obs_q.pop_front();
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected word", got, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag_q.pop_front();
        check(got == e, t, got, e);
      end
    end
  end

  task automatic xfer(input logic [31:0] cmd);
    @(negedge clk);
    if (data_avail) obs_q.push_back(tx_word);
    else check(tx_word == 32'h0, "R8 tx zero when empty", tx_word, 32'h0);
    dg_data  = cmd;
    dg_valid = 1'b1;
    @(negedge clk);
    dg_valid = 1'b0;
    dg_data  = '0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) xfer(32'h0);
  endtask

  task automatic serve(input logic [3:0] id, input bit chk_mem, input logic [6:0] ea, input logic [7:0] ed);
    int waitc;
    waitc = 0;
    while (!req_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    check(req_valid == 1'b1, "R1 request raised", {31'h0, req_valid}, 32'h1);
    check(req_id == id, "R1 request id", {28'h0, req_id}, {28'h0, id});
    if (chk_mem) begin
      check(req_addr == ea, "R2 address", {25'h0, req_addr}, {25'h0, ea});
      check(req_data == ed, "R2 data", {24'h0, req_data}, {24'h0, ed});
    end
    check(rsp_ready == 1'b0, "R12 no rsp_ready before handshake", {31'h0, rsp_ready}, 32'h0);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(rsp_ready == 1'b1, "R12 rsp_ready after handshake", {31'h0, rsp_ready}, 32'h1);
    push_exp(id);
    rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(data_avail == 1'b1, "R9 avail after load", {31'h0, data_avail}, 32'h1);
  endtask

  task automatic set_fields(input logic [7:0] seed);
    r_sf   = seed ^ 8'h11;
    r_pos  = {seed, ~seed, seed ^ 8'h5A};
    r_turn = {~seed, seed ^ 8'hC3, seed};
    r_eid  = seed + 8'd7;
    r_alm  = seed ^ 8'hF0;
    r_madr = {1'b0, seed[6:0]};
    r_mdat = ~seed;
    r_crx  = seed + 8'd1;
    r_ccal = seed + 8'd2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_avail == 1'b0, "R9 reset avail", {31'h0, data_avail}, 32'h0);
    check(cmd_err == 1'b0, "R11 reset err", {31'h0, cmd_err}, 32'h0);
    check(req_valid == 1'b0, "R12 reset req", {31'h0, req_valid}, 32'h0);
    check(tx_word == 32'h0, "R8 reset tx", tx_word, 32'h0);

    // R13: unlisted opcode while idle
    xfer(32'h9012_3456);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R13 no request", {31'h0, req_valid}, 32'h0);
    check(data_avail == 1'b0, "R13 nothing queued", {31'h0, data_avail}, 32'h0);
    check(cmd_err == 1'b0, "R13 no error", {31'h0, cmd_err}, 32'h0);

    // R7: version and protocol words
    expect_word({8'hFF, 8'h00, 8'h01, 8'h00}, "R7 version");
    xfer(32'hFF00_0000);
    check(data_avail == 1'b1, "R9 avail after version", {31'h0, data_avail}, 32'h1);
    repeat (2) @(negedge clk);
    check(req_valid == 1'b0, "R7 no request", {31'h0, req_valid}, 32'h0);
    drain(1);
    check(data_avail == 1'b0, "R9 avail falls", {31'h0, data_avail}, 32'h0);
    expect_word(32'h5441_4D54, "R7 protocol");
    xfer(32'hFE00_0000);
    drain(1);

    // R3, R4, R5, R6 over every encoder opcode
    set_fields(8'h21); xfer(32'h8000_0000); serve(4'h0, 0, '0, '0); drain(2);
    set_fields(8'h3C); xfer(32'h8100_0000); serve(4'h1, 0, '0, '0); drain(2);
    set_fields(8'h47); xfer(32'h8200_0000); serve(4'h2, 0, '0, '0); drain(2);
    set_fields(8'h9E); xfer(32'h8300_0000); serve(4'h3, 0, '0, '0);
    drain(4);
    check(data_avail == 1'b1, "R5 one word left", {31'h0, data_avail}, 32'h1);
    drain(1);
    check(data_avail == 1'b0, "R9 avail falls after five", {31'h0, data_avail}, 32'h0);
    set_fields(8'h5A); xfer(32'h8600_A53C); serve(4'h6, 1, 7'h3C, 8'hA5); drain(2);
    set_fields(8'h66); xfer(32'h8D00_0011); serve(4'hD, 1, 7'h11, 8'h00); drain(2);
    set_fields(8'h70); xfer(32'h8700_0000); serve(4'h7, 0, '0, '0); drain(2);
    set_fields(8'h81); xfer(32'h8800_0000); serve(4'h8, 0, '0, '0); drain(2);
    set_fields(8'hC2); xfer(32'h8C00_0000); serve(4'hC, 0, '0, '0); drain(2);

    // R10: last readout carries the next command
    set_fields(8'h13); xfer(32'h8000_0000); serve(4'h0, 0, '0, '0);
    drain(1);
    xfer(32'h8200_0000);
    set_fields(8'h14); serve(4'h2, 0, '0, '0);
    drain(1);
    expect_word(32'h5441_4D54, "R10 protocol on last readout");
    xfer(32'hFE00_0000);
    drain(1);
    check(cmd_err == 1'b0, "R10 no error", {31'h0, cmd_err}, 32'h0);

    // R11: command while the encoder is busy
    set_fields(8'h2B); xfer(32'h8000_0000);
    xfer(32'h8100_0000);
    check(cmd_err == 1'b1, "R11 err while busy", {31'h0, cmd_err}, 32'h1);
    serve(4'h0, 0, '0, '0);
    drain(2);

    // R11: command while words remain queued
    set_fields(8'h4D); xfer(32'h8000_0000); serve(4'h0, 0, '0, '0);
    xfer(32'h8300_0000);
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R11 ignored command", {31'h0, req_valid}, 32'h0);
    check(data_avail == 1'b1, "R11 queue intact", {31'h0, data_avail}, 32'h1);
    drain(1);
    check(data_avail == 1'b0, "R9 avail clear", {31'h0, data_avail}, 32'h0);
    check(cmd_err == 1'b1, "R11 err sticky", {31'h0, cmd_err}, 32'h1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected words read", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule